// File: doc/BRIEF.md
# SRAM Write-Timing Violation Monitor

This block is a passive observer on the pins of an asynchronous 16-bit static RAM bus. Every bus pin is sampled on a fast clock that is synchronous to the monitor. The monitor rebuilds the memory's internal write window from the pin samples. For every window that closes, it measures how long each participating signal had been stable and compares that time with a minimum threshold. Each threshold is a parameter in nanoseconds, and the monitor converts it to sample clocks from the sample period. When a rule is broken, the monitor raises a one-cycle pulse and a sticky flag for that rule.

The write window is open only while four conditions hold at once: the primary chip select is low (active), the secondary chip select is high (active), write-enable is low, and at least one byte-lane enable is low. The window closes on the first sample where any of these conditions fails. Whichever signal ended the window, all setup times are measured back from that closing sample.

The monitor also checks three further things:
- the spacing between consecutive write windows;
- that the address does not change inside a window;
- that the controller does not drive data while the memory is in an output-enabled read.

It also counts completed writes and records the address of the last write. The block is meant for a verification environment or a debug build, placed next to a memory controller that it does not disturb.

Top module: `sram_wr_monitor`

## Requirements
- R1: A write window is open on a sample where `ce1_n`=0, `ce2`=1, `we_n`=0 and at least one bit of `be_n` is 0. `wr_count` increments by one for each sample on which a window closes and never otherwise. A window whose byte enables are both inactive does not count.
- R2: When a window closes, `last_addr` takes the address seen on the last sample inside the window.
- R3: Rule bit 0 (data setup) fires at window close if any byte lane that was enabled on the last in-window sample had its `bus_dq` byte stable for fewer than 4 samples (25 ns at 8 ns). Lane 0 is `bus_dq[7:0]` with `be_n[0]`, and lane 1 is `bus_dq[15:8]` with `be_n[1]`. A disabled lane's data is ignored.
- R4: Rule bit 1 (write-enable width) fires at window close if `we_n` had been low for fewer than 5 samples (35 ns).
- R5: Rule bit 2 (select overlap) fires at window close if the chip-select condition had been active for fewer than 5 samples.
- R6: Rule bit 3 (byte overlap) fires at window close if any byte enable that was active had been active for fewer than 5 samples.
- R7: Rule bit 4 (address setup) fires at window close if the address had been stable for fewer than 5 samples. Rule bit 5 (address change) fires on any sample that is inside a window, follows an in-window sample, and carries a different address.
- R8: Rule bit 6 (cycle spacing) fires when a window opens fewer than 7 samples (55 ns) after the previous window opened. A spacing of exactly 7 samples is legal.
- R9: Rule bit 7 (bus contention) fires on any sample with `drive_en`=1, `oe_n`=0, chip select active, `we_n`=1 and a byte enable active. It does not fire when either chip select is inactive.
- R10: Each rule drives `viol_pulse` high for one cycle after the offending sample and sets `viol_sticky`. The sticky bit stays set until `clr` is high. With the default clear priority, a detection on the same sample as `clr` leaves the bit set.
- R11: After `rst`, `viol_pulse`, `viol_sticky`, `wr_count` and `last_addr` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| clr | input | 1 | Synchronous clear of the sticky flags |
| bus_addr | input | 19 | Sampled address pins |
| bus_dq | input | 16 | Sampled write data driven by the controller |
| ce1_n | input | 1 | Primary chip select, active low |
| ce2 | input | 1 | Secondary chip select, active high |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| be_n | input | 2 | Byte-lane enables, active low (bit 0 low byte) |
| drive_en | input | 1 | Controller is driving the data pins |
| viol_pulse | output | 8 | One-cycle detection pulse per rule |
| viol_sticky | output | 8 | Sticky flag per rule |
| wr_count | output | 16 | Number of closed write windows (wraps) |
| last_addr | output | 19 | Address of the most recent write |

## Verification
Assertions inside the RTL check the following on every cycle:
- the write counter moves by exactly one on a window close and stays still on every other sample;
- a sticky bit never drops without a clear;
- a clear with no new detection empties the bit;
- every pulse is backed by a set sticky bit;
- a contention pulse only follows a sample with the data drive on and the output enable low;
- the close-time and open-time rules pulse only after a close or an open.

Only the bench scenarios can show that each threshold sits at the correct sample count. They show this by placing lengths exactly at and one below each limit. The scenarios also cover window-spacing boundaries of six and seven samples, a disabled lane's data toggling freely, an address captured at close, and the set-over-clear priority.

// File: rtl/sram_wmon_pkg.sv
package sram_wmon_pkg;

   localparam int unsigned NUM_RULES    = 8;
   localparam int unsigned RULE_DSETUP  = 0;
   localparam int unsigned RULE_WEWIDTH = 1;
   localparam int unsigned RULE_SELOVL  = 2;
   localparam int unsigned RULE_BYTEOVL = 3;
   localparam int unsigned RULE_ASETUP  = 4;
   localparam int unsigned RULE_ACHG    = 5;
   localparam int unsigned RULE_CYCLE   = 6;
   localparam int unsigned RULE_CONTEND = 7;

   // Minimum time in ns -> sample clocks, rounded up so a legal bus never trips.
   function automatic int unsigned ns_to_clk(input int unsigned ns, input int unsigned period_ps);
      return (ns * 1000 + period_ps - 1) / period_ps;
   endfunction

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/wmon_age.sv
// Saturating stability timer: counts consecutive samples with an unchanged value.
module wmon_age #(
   parameter int unsigned W  = 1,
   parameter int unsigned CW = 3
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [W-1:0]  sig,
   output logic [CW-1:0] age
);

   logic [W-1:0] held;

   generate
      if (W < 1 || CW < 1) begin : g_bad_width
         $error("wmon_age: W and CW must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         held <= '0;
         age  <= '0;
      end else begin
         held <= sig;
         if (sig != held) begin
            age <= CW'(1);
         end else if (age != '1) begin
            age <= age + CW'(1);
         end
      end
   end

endmodule

// File: rtl/wmon_flags.sv
// Per-rule pulse and sticky register with a selectable clear priority.
module wmon_flags #(
   parameter int unsigned N        = 8,
   parameter bit          CLR_WINS = 1'b0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         clr,
   input  logic [N-1:0] hit,
   output logic [N-1:0] pulse,
   output logic [N-1:0] sticky
);

   generate
      if (N < 1) begin : g_bad_n
         $error("wmon_flags: N must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) pulse <= '0;
      else     pulse <= hit;
   end

   generate
      if (CLR_WINS) begin : g_clear_first
         always_ff @(posedge clk) begin
            if (rst)      sticky <= '0;
            else if (clr) sticky <= '0;
            else          sticky <= sticky | hit;
         end
         for (genvar i = 0; i < N; i++) begin : g_chk
            AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
               clr |=> !sticky[i]); // R10
         end
      end else begin : g_set_first
         always_ff @(posedge clk) begin
            if (rst) sticky <= '0;
            else     sticky <= (clr ? '0 : sticky) | hit;
         end
         for (genvar i = 0; i < N; i++) begin : g_chk
            AST_PULSE_BACKED: assert property (@(posedge clk) disable iff (rst)
               pulse[i] |-> sticky[i]); // R10
            AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
               (clr && !hit[i]) |=> !sticky[i]); // R10
         end
      end
   endgenerate

   for (genvar i = 0; i < N; i++) begin : g_hold
      AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (rst)
         (sticky[i] && !clr) |=> sticky[i]); // R10
   end

endmodule

// File: rtl/sram_wr_monitor.sv
module sram_wr_monitor
   import sram_wmon_pkg::*;
#(
   parameter int unsigned ADDR_W       = 19,
   parameter int unsigned DATA_W       = 16,
   parameter int unsigned LANE_W       = 8,
   parameter int unsigned CNT_W        = 16,
   parameter int unsigned SAMPLE_PS    = 8000,
   parameter int unsigned T_DSETUP_NS  = 25,
   parameter int unsigned T_WEWIDTH_NS = 35,
   parameter int unsigned T_SELOVL_NS  = 35,
   parameter int unsigned T_BYTEOVL_NS = 35,
   parameter int unsigned T_ASETUP_NS  = 35,
   parameter int unsigned T_CYCLE_NS   = 55,
   parameter bit          CLR_WINS     = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 clr,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [DATA_W-1:0]    bus_dq,
   input  logic                 ce1_n,
   input  logic                 ce2,
   input  logic                 we_n,
   input  logic                 oe_n,
   input  logic [DATA_W/LANE_W-1:0] be_n,
   input  logic                 drive_en,
   output logic [NUM_RULES-1:0] viol_pulse,
   output logic [NUM_RULES-1:0] viol_sticky,
   output logic [CNT_W-1:0]     wr_count,
   output logic [ADDR_W-1:0]    last_addr
);

   localparam int unsigned LANES     = DATA_W / LANE_W;
   localparam int unsigned N_DSETUP  = ns_to_clk(T_DSETUP_NS,  SAMPLE_PS);
   localparam int unsigned N_WEWIDTH = ns_to_clk(T_WEWIDTH_NS, SAMPLE_PS);
   localparam int unsigned N_SELOVL  = ns_to_clk(T_SELOVL_NS,  SAMPLE_PS);
   localparam int unsigned N_BYTEOVL = ns_to_clk(T_BYTEOVL_NS, SAMPLE_PS);
   localparam int unsigned N_ASETUP  = ns_to_clk(T_ASETUP_NS,  SAMPLE_PS);
   localparam int unsigned N_CYCLE   = ns_to_clk(T_CYCLE_NS,   SAMPLE_PS);
   localparam int unsigned N_MAX     = max2(max2(max2(N_DSETUP, N_WEWIDTH), max2(N_SELOVL, N_BYTEOVL)),
                                            max2(N_ASETUP, N_CYCLE));
   localparam int unsigned CW        = $clog2(N_MAX + 1);

   generate
      if (SAMPLE_PS == 0) begin : g_bad_period
         $error("sram_wr_monitor: SAMPLE_PS must be non-zero");
      end
      if (LANE_W == 0 || (DATA_W % LANE_W) != 0) begin : g_bad_lanes
         $error("sram_wr_monitor: DATA_W must be a whole number of lanes");
      end
      if (ADDR_W < 1 || CNT_W < 1) begin : g_bad_widths
         $error("sram_wr_monitor: ADDR_W and CNT_W must be at least 1");
      end
      if (N_DSETUP < 1 || N_CYCLE < 1 || N_ASETUP < 1) begin : g_bad_thresh
         $error("sram_wr_monitor: every threshold must be at least one sample");
      end
   endgenerate

   // ---------------- window reconstruction ----------------
   logic              sel_act, we_act, any_be, win, win_q, open_ev, close_ev, rd_en;
   logic [LANES-1:0]  be_act, be_q;
   logic [ADDR_W-1:0] addr_q;

   assign sel_act  = !ce1_n && ce2;
   assign we_act   = !we_n;
   assign be_act   = ~be_n;
   assign any_be   = |be_act;
   assign win      = sel_act && we_act && any_be;
   assign open_ev  = win && !win_q;
   assign close_ev = win_q && !win;
   assign rd_en    = sel_act && !we_act && any_be && !oe_n;

   always_ff @(posedge clk) begin
      if (rst) begin
         win_q  <= 1'b0;
         be_q   <= '0;
         addr_q <= '0;
      end else begin
         win_q  <= win;
         be_q   <= be_act;
         addr_q <= bus_addr;
      end
   end

   // ---------------- stability timers ----------------
   logic [CW-1:0] sel_age, we_age, addr_age;

   wmon_age #(.W(1), .CW(CW)) u_sel_age (
      .clk(clk), .rst(rst), .sig(sel_act), .age(sel_age));
   wmon_age #(.W(1), .CW(CW)) u_we_age (
      .clk(clk), .rst(rst), .sig(we_act), .age(we_age));
   wmon_age #(.W(ADDR_W), .CW(CW)) u_addr_age (
      .clk(clk), .rst(rst), .sig(bus_addr), .age(addr_age));

   logic [LANES-1:0] dat_short, be_short;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [CW-1:0] dat_age, ben_age;
      wmon_age #(.W(LANE_W), .CW(CW)) u_dat_age (
         .clk(clk), .rst(rst), .sig(bus_dq[l*LANE_W +: LANE_W]), .age(dat_age));
      wmon_age #(.W(1), .CW(CW)) u_be_age (
         .clk(clk), .rst(rst), .sig(be_act[l]), .age(ben_age));
      // Only lanes enabled on the last in-window sample are judged.
      assign dat_short[l] = be_q[l] && (dat_age < CW'(N_DSETUP));
      assign be_short[l]  = be_q[l] && (ben_age < CW'(N_BYTEOVL));
   end

   // ---------------- open-to-open spacing ----------------
   logic [CW-1:0] gap;
   logic          seen_open;

   always_ff @(posedge clk) begin
      if (rst) begin
         gap       <= '0;
         seen_open <= 1'b0;
      end else if (open_ev) begin
         gap       <= CW'(1);
         seen_open <= 1'b1;
      end else if (gap != '1) begin
         gap <= gap + CW'(1);
      end
   end

   // ---------------- rule evaluation ----------------
   logic [NUM_RULES-1:0] hit;

   always_comb begin
      hit               = '0;
      hit[RULE_DSETUP]  = close_ev && (|dat_short);
      hit[RULE_WEWIDTH] = close_ev && (we_age   < CW'(N_WEWIDTH));
      hit[RULE_SELOVL]  = close_ev && (sel_age  < CW'(N_SELOVL));
      hit[RULE_BYTEOVL] = close_ev && (|be_short);
      hit[RULE_ASETUP]  = close_ev && (addr_age < CW'(N_ASETUP));
      hit[RULE_ACHG]    = win && win_q && (bus_addr != addr_q);
      hit[RULE_CYCLE]   = open_ev && seen_open && (gap < CW'(N_CYCLE));
      hit[RULE_CONTEND] = drive_en && rd_en;
   end

   wmon_flags #(.N(NUM_RULES), .CLR_WINS(CLR_WINS)) u_flags (
      .clk(clk), .rst(rst), .clr(clr), .hit(hit),
      .pulse(viol_pulse), .sticky(viol_sticky));

   // ---------------- write bookkeeping ----------------
   always_ff @(posedge clk) begin
      if (rst) begin
         wr_count  <= '0;
         last_addr <= '0;
      end else if (close_ev) begin
         wr_count  <= wr_count + CNT_W'(1);
         last_addr <= addr_q;
      end
   end

   // ---------------- assertions ----------------
   AST_COUNT_ON_CLOSE: assert property (@(posedge clk) disable iff (rst)
      close_ev |=> (wr_count == $past(wr_count) + CNT_W'(1))); // R1
   AST_COUNT_STILL: assert property (@(posedge clk) disable iff (rst)
      !close_ev |=> $stable(wr_count)); // R1
   AST_ADDR_ON_CLOSE_ONLY: assert property (@(posedge clk) disable iff (rst)
      !close_ev |=> $stable(last_addr)); // R2
   AST_SETUP_AT_CLOSE: assert property (@(posedge clk) disable iff (rst)
      viol_pulse[RULE_DSETUP] |-> ($past(win_q) && !$past(win))); // R3
   AST_CYCLE_AT_OPEN: assert property (@(posedge clk) disable iff (rst)
      viol_pulse[RULE_CYCLE] |-> ($past(win) && !$past(win_q))); // R8
   AST_CONTEND_SOURCE: assert property (@(posedge clk) disable iff (rst)
      viol_pulse[RULE_CONTEND] |-> $past(drive_en && !oe_n && we_n)); // R9

endmodule

// File: tb/tb_sram_wr_monitor.sv
module tb_sram_wr_monitor;

   logic        clk = 1'b0;
   logic        rst, clr;
   logic [18:0] bus_addr;
   logic [15:0] bus_dq;
   logic        ce1_n, ce2, we_n, oe_n, drive_en;
   logic [1:0]  be_n;
   logic [7:0]  viol_pulse, viol_sticky;
   logic [15:0] wr_count;
   logic [18:0] last_addr;

   always #4 clk = ~clk; // 125 MHz

   sram_wr_monitor dut (
      .clk(clk), .rst(rst), .clr(clr), .bus_addr(bus_addr), .bus_dq(bus_dq),
      .ce1_n(ce1_n), .ce2(ce2), .we_n(we_n), .oe_n(oe_n), .be_n(be_n),
      .drive_en(drive_en), .viol_pulse(viol_pulse), .viol_sticky(viol_sticky),
      .wr_count(wr_count), .last_addr(last_addr));

   // Thresholds in 8 ns samples, rounded up: 25ns->4, 35ns->5, 55ns->7.
   localparam int SD = 4, PW = 5, WC = 7;

   typedef struct packed {
      logic [3:0]  c, w, b, a, d;
      logic [1:0]  m;
      logic [18:0] addr;
      logic [15:0] data;
   } vec_t;

   localparam int NV = 9;
   localparam vec_t VECS [NV] = '{
      '{4'd6, 4'd6, 4'd6, 4'd6, 4'd6, 2'b11, 19'h00010, 16'h1234},
      '{4'd5, 4'd5, 4'd5, 4'd5, 4'd4, 2'b11, 19'h7FFFF, 16'hA5C3},
      '{4'd6, 4'd6, 4'd6, 4'd6, 4'd3, 2'b11, 19'h00022, 16'h0F0F},
      '{4'd8, 4'd4, 4'd8, 4'd8, 4'd4, 2'b11, 19'h12345, 16'h8001},
      '{4'd4, 4'd8, 4'd8, 4'd8, 4'd4, 2'b01, 19'h00100, 16'h00FF},
      '{4'd8, 4'd8, 4'd4, 4'd8, 4'd4, 2'b10, 19'h3AAAA, 16'hFF00},
      '{4'd8, 4'd8, 4'd8, 4'd4, 4'd4, 2'b11, 19'h05555, 16'h5A5A},
      '{4'd7, 4'd7, 4'd7, 4'd7, 4'd7, 2'b11, 19'h00001, 16'hCAFE},
      '{4'd5, 4'd6, 4'd7, 4'd5, 4'd2, 2'b11, 19'h40000, 16'h7E7E}
   };

   int nchk = 0, nerr = 0, cycles = 0;
   int exp_cnt = 0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic idle_bus();
      ce1_n = 1'b1; ce2 = 1'b0; we_n = 1'b1; be_n = 2'b11; drive_en = 1'b0;
   endtask

   function automatic logic [7:0] expect_flags(input vec_t v);
      int win;
      logic [7:0] e;
      win = v.c;
      if (v.w < win) win = v.w;
      if (v.b < win) win = v.b;
      e = '0;
      e[0] = (v.d < SD);  // R3
      e[1] = (v.w < PW);  // R4
      e[2] = (v.c < PW);  // R5
      e[3] = (v.b < PW);  // R6
      e[4] = (v.a < PW);  // R7 setup
      e[5] = (v.a < win); // R7 change inside window
      return e;
   endfunction

   // Block of T samples in which each signal is active for its last x samples.
   task automatic do_block(input vec_t v, input bit hi_toggle);
      int t;
      t = v.c;
      if (v.w > t) t = v.w;
      if (v.b > t) t = v.b;
      if (v.a > t) t = v.a;
      if (v.d > t) t = v.d;
      idle_bus();
      bus_addr = ~v.addr; bus_dq = ~v.data;
      step();
      for (int k = 0; k < t; k++) begin
         ce1_n    = !(k >= t - v.c);
         ce2      =  (k >= t - v.c);
         we_n     = !(k >= t - v.w);
         be_n     = (k >= t - v.b) ? ~v.m : 2'b11;
         bus_addr = (k >= t - v.a) ? v.addr : ~v.addr;
         bus_dq   = (k >= t - v.d) ? v.data : ~v.data;
         if (hi_toggle) bus_dq[15:8] = 8'(k * 37 + 1);
         drive_en = 1'b1;
         step();
      end
      idle_bus();
      bus_addr = v.addr; bus_dq = v.data;
      step();
      for (int k = 0; k < 6; k++) step();
   endtask

   task automatic raw_win(input int n);
      for (int k = 0; k < n; k++) begin
         ce1_n = 1'b0; ce2 = 1'b1; we_n = 1'b0; be_n = 2'b00; drive_en = 1'b1;
         step();
      end
      idle_bus();
      step();
   endtask

   task automatic do_clr();
      clr = 1'b1; step(); clr = 1'b0;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         nerr++; nchk++;
         $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cycles);
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end

   initial begin
      rst = 1'b1; clr = 1'b0; oe_n = 1'b1;
      bus_addr = '0; bus_dq = '0;
      idle_bus();
      @(negedge clk);
      repeat (3) step();
      rst = 1'b0;
      step();
      // R11 reset state
      chk("R11 pulse", 32'(viol_pulse), 0);
      chk("R11 sticky", 32'(viol_sticky), 0);
      chk("R11 count", 32'(wr_count), 0);
      chk("R11 last_addr", 32'(last_addr), 0);
      repeat (8) step();

      // Vector table: R1 R2 R3 R4 R5 R6 R7
      for (int i = 0; i < NV; i++) begin
         do_block(VECS[i], 1'b0);
         exp_cnt++;
         chk($sformatf("R3-R7 flags vec%0d", i), 32'(viol_sticky), 32'(expect_flags(VECS[i])));
         chk($sformatf("R1 count vec%0d", i), 32'(wr_count), 32'(exp_cnt));
         chk($sformatf("R2 last_addr vec%0d", i), 32'(last_addr), 32'(VECS[i].addr));
         do_clr();
         chk($sformatf("R10 cleared vec%0d", i), 32'(viol_sticky), 0);
      end

      // R3: disabled high lane toggles freely, low lane stable
      do_block('{4'd6, 4'd6, 4'd6, 4'd6, 4'd6, 2'b01, 19'h00ABC, 16'h0042}, 1'b1);
      exp_cnt++;
      chk("R3 idle lane ignored", 32'(viol_sticky), 0);
      do_clr();

      // R1: no byte enable -> no window, no count
      bus_addr = 19'h00777;
      for (int k = 0; k < 6; k++) begin
         ce1_n = 1'b0; ce2 = 1'b1; we_n = 1'b0; be_n = 2'b11; step();
      end
      idle_bus(); step(); step();
      chk("R1 no byte no count", 32'(wr_count), 32'(exp_cnt));

      // R8: spacing 6 flags, spacing 7 does not
      bus_addr = 19'h01111; bus_dq = 16'h2222;
      repeat (10) step();
      raw_win(5);
      raw_win(5);
      exp_cnt += 2;
      repeat (6) step();
      chk("R8 spacing 6", 32'(viol_sticky), 32'h40);
      do_clr();
      repeat (10) step();
      raw_win(5);
      step();
      raw_win(5);
      exp_cnt += 2;
      repeat (6) step();
      chk("R8 spacing 7 legal", 32'(viol_sticky), 0);
      chk("R1 count after raw", 32'(wr_count), 32'(exp_cnt));

      // R9: write with output enable low causes no contention
      oe_n = 1'b0;
      do_block('{4'd6, 4'd6, 4'd6, 4'd6, 4'd6, 2'b11, 19'h00333, 16'h4444}, 1'b0);
      exp_cnt++;
      chk("R9 write with oe low", 32'(viol_sticky), 0);

      // R9: deselected chip with drive and oe low is ignored
      ce1_n = 1'b1; ce2 = 1'b1; we_n = 1'b1; be_n = 2'b00; drive_en = 1'b1;
      step();
      chk("R9 deselected pulse", 32'(viol_pulse), 0);

      // R9 + R10: contention on the same sample as clr -> set wins
      ce1_n = 1'b0; ce2 = 1'b1; clr = 1'b1;
      step();
      clr = 1'b0; drive_en = 1'b0;
      chk("R9 contention pulse", 32'(viol_pulse), 32'h80);
      chk("R10 set beats clear", 32'(viol_sticky), 32'h80);
      step();
      chk("R10 pulse one cycle", 32'(viol_pulse), 0);
      chk("R10 sticky holds", 32'(viol_sticky), 32'h80);
      oe_n = 1'b1; idle_bus();
      do_clr();
      chk("R10 clear empties", 32'(viol_sticky), 0);

      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

endmodule